// File: doc/BRIEF.md
# Supply-Loss Timestamp Recorder

This block keeps a record of when the main supply went away and when it came back. A timekeeping core elsewhere on the chip supplies a free-running time-of-day bus with four bytes: minute, hour, date, and a weekday/month byte. A supply-good level comes from an analog trip detector. The block synchronises that level and finds its edges. On each edge it copies the time bus into one of two four-byte banks. A falling edge fills the power-down bank. A rising edge fills the power-up bank.

A power-down capture also sets a sticky "ran on backup" flag. Software reads the flag, and both banks, through a small single-cycle register port. Software acknowledges an event by writing the flag to zero. That write also wipes both banks.

Captures are taken only when the oscillator-running input and the backup-present input are both high. An edge seen while either is low is dropped, and nothing is loaded.

Top module: `supply_event_stamp`

## Requirements
- R1: After reset, every register in the map reads 0. This covers the flag register at address 0x03 and all eight stamp registers at 0x18–0x1F.
- R2: A falling edge of `supplyGood` loads `timeNow` into the power-down bank on the third rising clock edge after the change. The bytes are ordered as follows:
  - address 0x18 holds `timeNow[7:0]` (minute);
  - address 0x19 holds `timeNow[15:8]` (hour);
  - address 0x1A holds `timeNow[23:16]` (date);
  - address 0x1B holds `timeNow[31:24]` (weekday/month).
- R3: A rising edge of `supplyGood` loads `timeNow` into the power-up bank with the same timing and the same byte order, at addresses 0x1C–0x1F.
- R4: A power-down capture sets the flag, which reads as bit 4 of address 0x03 (value 0x10). The flag then stays set until software clears it. A power-up capture does not change the flag.
- R5: A write to 0x03 with bit 4 at 0 clears the flag and all eight stamp registers. A write to 0x03 with bit 4 at 1 changes nothing.
- R6: No capture takes place, and the flag is left as it is, for an edge that arrives while `oscRunning` or `backupPresent` is low.
- R7: Writes to 0x18–0x1F are ignored.
- R8: Each transition of `supplyGood` causes exactly one capture. While the level stays steady, a changing `timeNow` does not alter a stored stamp.
- R9: A falling edge that arrives while the flag is already set still overwrites the power-down bank.
- R10: Reads of any address other than 0x03 and 0x18–0x1F return 0. The bits of 0x03 other than bit 4 read 0.
- R11: A capture and a clearing write can land in the same cycle. In that case:
  - the capturing bank takes the new time;
  - the other bank is cleared;
  - the flag ends set if the capture was a power-down capture, and cleared if it was a power-up capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| timeNow | input | 32 | Running time: minute, hour, date, weekday/month (LSB first) |
| supplyGood | input | 1 | Asynchronous main-supply-above-trip level |
| oscRunning | input | 1 | Oscillator running; gates captures |
| backupPresent | input | 1 | Backup supply present; gates captures |
| regAddr | input | 5 | Register address |
| regWe | input | 1 | Write enable, sampled at the clock edge |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |

## Verification
A software clear and a hardware capture can fall in the same cycle. The bench provokes this by timing the clearing write to 0x03 so that it is sampled on exactly the third clock edge after a `supplyGood` change, which is the edge that loads the bank.

The case is run twice, once for a rising change and once for a falling change. Each time the bench checks three things: the capturing bank holds the new time, the opposite bank reads zero, and the flag has the value that R11 gives for that direction.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  // Strobes from control to datapath, each valid for one cycle
  typedef struct packed {
    logic loadDown;  // copy time into power-down bank
    logic loadUp;    // copy time into power-up bank
    logic clearAll;  // software acknowledge: wipe both banks
  } stampStrobes_t;
endpackage

// File: rtl/stamp_ctrl.sv
module stamp_ctrl
  import stamp_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int CTRL_ADDR   = 3,
  parameter int FLAG_BIT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyGood,
  input  logic              oscRunning,
  input  logic              backupPresent,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output stampStrobes_t     strb,
  output logic              batFlag
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic [SYNC_STAGES-1:0] syncChain;
  logic prevGood;
  logic syncedGood;
  logic fallEdge;
  logic riseEdge;
  logic captureOk;
  logic clearReq;

  // The synchroniser resets to "supply good", so reset itself never makes an edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
      prevGood  <= 1'b1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], supplyGood};
      prevGood  <= syncedGood;
    end
  end

  assign syncedGood = syncChain[SYNC_STAGES-1];
  assign fallEdge   = prevGood & ~syncedGood;
  assign riseEdge   = ~prevGood & syncedGood;
  assign captureOk  = oscRunning & backupPresent;
  assign clearReq   = regWe && (regAddr == CTRL_A) && !regWdata[FLAG_BIT];

  always_comb begin
    strb.loadDown = fallEdge & captureOk;
    strb.loadUp   = riseEdge & captureOk;
    strb.clearAll = clearReq;
  end

  // A capture takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              batFlag <= 1'b0;
    else if (strb.loadDown) batFlag <= 1'b1;
    else if (clearReq)      batFlag <= 1'b0;
  end

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDown |=> batFlag);
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (batFlag && !strb.clearAll) |=> batFlag);
  p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearAll && !strb.loadDown) |=> !batFlag);
  p_single_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadDown || strb.loadUp) |=> !(strb.loadDown || strb.loadUp));
endmodule

// File: rtl/stamp_datapath.sv
module stamp_datapath
  import stamp_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int STAMP_BYTES = 4,
  parameter int CTRL_ADDR   = 3,
  parameter int FLAG_BIT    = 4,
  parameter int DOWN_BASE   = 24,
  parameter int UP_BASE     = 28
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  stampStrobes_t                 strb,
  input  logic                          batFlag,
  input  logic [DATA_W*STAMP_BYTES-1:0] timeNow,
  input  logic [ADDR_W-1:0]             regAddr,
  output logic [DATA_W-1:0]             regRdata
);
  localparam int STAMP_W = DATA_W * STAMP_BYTES;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic [STAMP_W-1:0]     downBank;
  logic [STAMP_W-1:0]     upBank;
  logic [STAMP_BYTES-1:0] downHit;
  logic [STAMP_BYTES-1:0] upHit;

  // A bank that is loading ignores a clear arriving in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              downBank <= '0;
    else if (strb.loadDown) downBank <= timeNow;
    else if (strb.clearAll) downBank <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upBank <= '0;
    else if (strb.loadUp)   upBank <= timeNow;
    else if (strb.clearAll) upBank <= '0;
  end

  for (genvar g = 0; g < STAMP_BYTES; g++) begin : g_hit
    assign downHit[g] = (regAddr == ADDR_W'(DOWN_BASE + g));
    assign upHit[g]   = (regAddr == ADDR_W'(UP_BASE + g));
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == CTRL_A) regRdata[FLAG_BIT] = batFlag;
    for (int i = 0; i < STAMP_BYTES; i++) begin
      if (downHit[i]) regRdata = downBank[i*DATA_W +: DATA_W];
      if (upHit[i])   regRdata = upBank[i*DATA_W +: DATA_W];
    end
  end

  p_down_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDown |=> downBank == $past(timeNow));
  p_up_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadUp |=> upBank == $past(timeNow));
  p_down_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadDown && !strb.clearAll) |=> $stable(downBank));
  p_up_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadUp && !strb.clearAll) |=> $stable(upBank));
  p_coincide_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearAll && strb.loadUp) |=> downBank == '0);
endmodule

// File: rtl/supply_event_stamp.sv
module supply_event_stamp
  import stamp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STAMP_BYTES = 4,
  parameter int ADDR_W      = 5,
  parameter int CTRL_ADDR   = 3,
  parameter int FLAG_BIT    = 4,
  parameter int DOWN_BASE   = 24,
  parameter int UP_BASE     = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [DATA_W*STAMP_BYTES-1:0] timeNow,
  input  logic                          supplyGood,
  input  logic                          oscRunning,
  input  logic                          backupPresent,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWe,
  input  logic [DATA_W-1:0]             regWdata,
  output logic [DATA_W-1:0]             regRdata
);
  stampStrobes_t strb;
  logic batFlag;

  stamp_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .FLAG_BIT(FLAG_BIT), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood),
    .oscRunning(oscRunning), .backupPresent(backupPresent),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .strb(strb), .batFlag(batFlag)
  );

  stamp_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAMP_BYTES(STAMP_BYTES),
    .CTRL_ADDR(CTRL_ADDR), .FLAG_BIT(FLAG_BIT),
    .DOWN_BASE(DOWN_BASE), .UP_BASE(UP_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .batFlag(batFlag),
    .timeNow(timeNow), .regAddr(regAddr), .regRdata(regRdata)
  );
endmodule

// File: tb/supply_event_stamp_tb.sv
module supply_event_stamp_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] timeNow = '0;
  logic        supplyGood = 1;
  logic        oscRunning = 1;
  logic        backupPresent = 1;
  logic [4:0]  regAddr;
  logic        regWe = 0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;

  logic       wrActive = 0;
  logic [4:0] wrAddr = '0;
  logic [4:0] monAddr = '0;
  logic       monBusy = 0;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [4:0] qAddr[$];
  logic [7:0] qData[$];
  string      qTag[$];

  assign regAddr = wrActive ? wrAddr : monAddr;

  always #5 clk = ~clk;

  supply_event_stamp u_dut (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .supplyGood(supplyGood),
    .oscRunning(oscRunning), .backupPresent(backupPresent),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata)
  );

  // Monitor: pops expected items and compares them against the read port
  initial begin
    forever begin
      @(negedge clk);
      if (qAddr.size() != 0) begin
        logic [4:0] a;
        logic [7:0] d;
        string t;
        monBusy = 1;
        a = qAddr.pop_front();
        d = qData.pop_front();
        t = qTag.pop_front();
        monAddr = a;
        #1;
        compared++;
        if (regRdata !== d) begin
          mismatched++;
          $display("FAIL %s addr=0x%02h actual=0x%02h expected=0x%02h", t, a, regRdata, d);
        end
        monBusy = 0;
      end
    end
  end

  task automatic expectReg(input logic [4:0] a, input logic [7:0] d, input string t);
    qAddr.push_back(a);
    qData.push_back(d);
    qTag.push_back(t);
    wait (qAddr.size() == 0 && !monBusy);
  endtask

  task automatic expectBank(input logic [4:0] base, input logic [31:0] v, input string t);
    for (int i = 0; i < 4; i++) expectReg(base + 5'(i), v[i*8 +: 8], t);
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wrActive = 1; wrAddr = a; regWdata = d; regWe = 1;
    @(negedge clk);
    regWe = 0; wrActive = 0;
  endtask

  // Change the supply level and wait past the capture edge (third rising edge)
  task automatic supplyTo(input logic lvl);
    @(negedge clk);
    supplyGood = lvl;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    expectReg(5'h03, 8'h00, "R1");
    expectBank(5'h18, 32'h0, "R1");
    expectBank(5'h1C, 32'h0, "R1");

    // R2 / R4 power-down capture
    timeNow = 32'h0A_15_09_30;
    supplyTo(0);
    expectBank(5'h18, 32'h0A_15_09_30, "R2");
    expectReg(5'h03, 8'h10, "R4");
    expectBank(5'h1C, 32'h0, "R2");

    // R8 steady level: no recapture
    timeNow = 32'h0B_16_10_31;
    repeat (6) @(negedge clk);
    expectBank(5'h18, 32'h0A_15_09_30, "R8");

    // R7 stamp writes ignored
    writeReg(5'h18, 8'hFF);
    writeReg(5'h1D, 8'hEE);
    expectReg(5'h18, 8'h30, "R7");
    expectReg(5'h1D, 8'h00, "R7");

    // R3 power-up capture; flag unchanged (R4)
    timeNow = 32'h0B_16_11_45;
    supplyTo(1);
    expectBank(5'h1C, 32'h0B_16_11_45, "R3");
    expectReg(5'h03, 8'h10, "R4");

    // R10 unmapped reads
    expectReg(5'h00, 8'h00, "R10");
    expectReg(5'h04, 8'h00, "R10");
    expectReg(5'h17, 8'h00, "R10");
    expectReg(5'h10, 8'h00, "R10");

    // R5 writing bit4=1 does nothing, bit4=0 wipes all
    writeReg(5'h03, 8'h10);
    expectReg(5'h03, 8'h10, "R5");
    expectReg(5'h19, 8'h09, "R5");
    writeReg(5'h03, 8'hEF);
    expectReg(5'h03, 8'h00, "R5");
    expectBank(5'h18, 32'h0, "R5");
    expectBank(5'h1C, 32'h0, "R5");

    // R6 suppression by oscillator and by backup absence
    oscRunning = 0;
    timeNow = 32'h01_02_03_04;
    supplyTo(0);
    expectBank(5'h18, 32'h0, "R6");
    expectReg(5'h03, 8'h00, "R6");
    oscRunning = 1;
    backupPresent = 0;
    supplyTo(1);
    expectBank(5'h1C, 32'h0, "R6");
    backupPresent = 1;

    // R9 fall while flag set overwrites down bank
    timeNow = 32'h02_03_12_00;
    supplyTo(0);
    timeNow = 32'h02_03_12_05;
    supplyTo(1);
    expectReg(5'h03, 8'h10, "R9");
    timeNow = 32'h02_04_07_59;
    supplyTo(0);
    expectBank(5'h18, 32'h02_04_07_59, "R9");
    expectBank(5'h1C, 32'h02_03_12_05, "R9");

    // R11 rise coincident with clear
    timeNow = 32'h03_05_08_20;
    @(negedge clk); supplyGood = 1;
    repeat (2) @(negedge clk);
    wrActive = 1; wrAddr = 5'h03; regWdata = 8'h00; regWe = 1;
    @(negedge clk); regWe = 0; wrActive = 0;
    repeat (2) @(negedge clk);
    expectBank(5'h1C, 32'h03_05_08_20, "R11");
    expectBank(5'h18, 32'h0, "R11");
    expectReg(5'h03, 8'h00, "R11");

    // R11 fall coincident with clear
    timeNow = 32'h03_06_22_10;
    @(negedge clk); supplyGood = 0;
    repeat (2) @(negedge clk);
    wrActive = 1; wrAddr = 5'h03; regWdata = 8'h00; regWe = 1;
    @(negedge clk); regWe = 0; wrActive = 0;
    repeat (2) @(negedge clk);
    expectBank(5'h18, 32'h03_06_22_10, "R11");
    expectBank(5'h1C, 32'h0, "R11");
    expectReg(5'h03, 8'h10, "R11");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run hung actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule